// File: doc/BRIEF.md
# Signed Arithmetic Shifter with Flags

This block performs a signed arithmetic shift whose direction and distance come from a single two's-complement count. It works in two widths: a single 16-bit word, or a 32-bit pair built from two words, the first word high and the second low. A positive count shifts left with zero fill, a negative count shifts right and replicates the sign bit. Along with the shifted value the block reports four condition flags: negative, zero, overflow (sign change) and carry (the last bit pushed out).

The surrounding datapath presents the operand word(s), a count word and a width select with a one-cycle valid strobe. One clock later the result word(s) and flags appear with a matching valid flag, and they hold until the next strobe. Fetching operands and writing results back stay with the caller.

Top module: `asr_shift_unit`

## Requirements
- R1: Only bits [5:0] of `count_i` affect the result and flags; bits [15:6] have no effect.
- R2: A count of 0 returns the operand unchanged, with C = 0 and V = 0.
- R3: A count k from 1 to 31 shifts left by k with zero fill, and C is the last bit pushed out of the top (operand bit W-k, W being 16 or 32). In 16-bit mode a count of 16 or more gives a zero result, with C equal to operand bit 0 at 16 and C = 0 above 16.
- R4: A count k from 32 to 63 shifts right arithmetically by 64-k, filling with the sign bit, and C is the last bit pushed out of the bottom (operand bit 63-k, or the sign bit when 64-k exceeds the width).
- R5: N equals the most significant bit of the result, and Z is 1 exactly when the whole result (both words in pair mode) is zero.
- R6: V is 1 exactly when the result's most significant bit differs from the operand's most significant bit, in both modes.
- R7: With `pair_i` = 1 the operand is {`hi_i`, `lo_i`} and the result is returned as {`hi_o`, `lo_o`}. With `pair_i` = 0 the operand is `hi_i` alone, the result is on `hi_o`, `lo_o` is 0 and `lo_i` has no effect.
- R8: `valid_o` is 1 in exactly the cycle after each cycle with `valid_i` = 1; results and flags change only on such cycles and hold otherwise, also when back-to-back strobes arrive.
- R9: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operands and count are presented this cycle |
| pair_i | input | 1 | 1: 32-bit pair shift, 0: 16-bit single shift |
| hi_i | input | 16 | Single operand, or high word of the pair |
| lo_i | input | 16 | Low word of the pair |
| count_i | input | 16 | Count word; low 6 bits are the signed shift count |
| valid_o | output | 1 | Result registered from last cycle's strobe |
| hi_o | output | 16 | Single result, or high word of the pair result |
| lo_o | output | 16 | Low word of the pair result, 0 in single mode |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Sign-change flag |
| flag_c_o | output | 1 | Carry: last bit shifted out |

## Verification
The bench aims at the count boundaries: 0, 1, 15, 16, 17, 31, 32, 33 and 63, in both widths. A design that treated 32 as a left shift, took the wrong bit as carry, or used the wrong right distance would report the wrong carry or result there. It drives counts with junk in the upper bits, which catches a decoder that reads more than six bits. It drives pair operands whose high word is zero and low word is not, which exposes a zero flag built from one word only. It also drives single-mode strobes with a live low input, which shows whether the low word leaks into the single result, and it sends back-to-back strobes and idle gaps to check that outputs neither slip a cycle nor drift while idle.

// File: rtl/asr_pkg.sv
package asr_pkg;

  typedef enum logic [1:0] {
    SHIFT_NONE  = 2'd0,
    SHIFT_LEFT  = 2'd1,
    SHIFT_RIGHT = 2'd2
  } shift_dir_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

endpackage

// File: rtl/asr_count_dec.sv
module asr_count_dec
  import asr_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic [CNT_W-1:0] cnt_i,
  output shift_dir_e       dir_o,
  output logic [CNT_W-1:0] amt_o
);

  always_comb begin
    if (cnt_i == '0) begin
      dir_o = SHIFT_NONE;
      amt_o = '0;
    end else if (!cnt_i[CNT_W-1]) begin
      dir_o = SHIFT_LEFT;
      amt_o = cnt_i;
    end else begin
      // right distance is the magnitude of the negative count
      dir_o = SHIFT_RIGHT;
      amt_o = '0 - cnt_i;
    end
  end

endmodule

// File: rtl/asr_shift_core.sv
module asr_shift_core
  import asr_pkg::*;
#(
  parameter int W     = 16,
  parameter int CNT_W = 6
) (
  input  logic [W-1:0]     x_i,
  input  shift_dir_e       dir_i,
  input  logic [CNT_W-1:0] amt_i,
  output logic [W-1:0]     res_o,
  output logic             carry_o
);

  logic [2*W-1:0]      left_full;
  logic signed [W:0]   right_full;

  always_comb begin
    // bit W of the widened left value is the last bit pushed out of the top
    left_full  = {{W{1'b0}}, x_i};
    left_full  = left_full << amt_i;
    // guard bit below the lsb catches the last bit pushed out of the bottom
    right_full = $signed({x_i, 1'b0});
    right_full = right_full >>> amt_i;

    unique case (dir_i)
      SHIFT_LEFT: begin
        res_o   = left_full[W-1:0];
        carry_o = left_full[W];
      end
      SHIFT_RIGHT: begin
        res_o   = right_full[W:1];
        carry_o = right_full[0];
      end
      default: begin
        res_o   = x_i;
        carry_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/asr_flag_gen.sv
module asr_flag_gen
  import asr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] res_i,
  input  logic         src_msb_i,
  input  logic         carry_i,
  output flags_t       flags_o
);

  always_comb begin
    flags_o.n = res_i[W-1];
    flags_o.z = (res_i == '0);
    flags_o.v = res_i[W-1] ^ src_msb_i;
    flags_o.c = carry_i;
  end

endmodule

// File: rtl/asr_shift_unit.sv
module asr_shift_unit
  import asr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              pair_i,
  input  logic [DATA_W-1:0] hi_i,
  input  logic [DATA_W-1:0] lo_i,
  input  logic [DATA_W-1:0] count_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] hi_o,
  output logic [DATA_W-1:0] lo_o,
  output logic              flag_n_o,
  output logic              flag_z_o,
  output logic              flag_v_o,
  output logic              flag_c_o
);

  localparam int PAIR_W = 2 * DATA_W;
  localparam int NUM_W  = 2;

  shift_dir_e       dir;
  logic [CNT_W-1:0] amt;

  asr_count_dec #(.CNT_W(CNT_W)) u_dec (
    .cnt_i (count_i[CNT_W-1:0]),
    .dir_o (dir),
    .amt_o (amt)
  );

  // one core per width: index 0 single word, index 1 register pair
  logic [PAIR_W-1:0] res_al [NUM_W];
  logic              cy     [NUM_W];

  for (genvar g = 0; g < NUM_W; g++) begin : g_core
    localparam int CW = (g == 0) ? DATA_W : PAIR_W;
    logic [CW-1:0] x;
    logic [CW-1:0] r;

    if (g == 0) begin : g_single
      assign x = hi_i;
    end else begin : g_pair
      assign x = {hi_i, lo_i};
    end

    asr_shift_core #(.W(CW), .CNT_W(CNT_W)) u_core (
      .x_i     (x),
      .dir_i   (dir),
      .amt_i   (amt),
      .res_o   (r),
      .carry_o (cy[g])
    );

    // left-align so the msb sits at the same place for both widths
    if (CW == PAIR_W) begin : g_full
      assign res_al[g] = r;
    end else begin : g_pad
      assign res_al[g] = {r, {(PAIR_W-CW){1'b0}}};
    end
  end

  logic [PAIR_W-1:0] res_sel;
  logic              cy_sel;
  flags_t            flags;

  assign res_sel = pair_i ? res_al[1] : res_al[0];
  assign cy_sel  = pair_i ? cy[1]     : cy[0];

  asr_flag_gen #(.W(PAIR_W)) u_flags (
    .res_i     (res_sel),
    .src_msb_i (hi_i[DATA_W-1]),
    .carry_i   (cy_sel),
    .flags_o   (flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      hi_o     <= '0;
      lo_o     <= '0;
      flag_n_o <= 1'b0;
      flag_z_o <= 1'b0;
      flag_v_o <= 1'b0;
      flag_c_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        hi_o     <= res_sel[PAIR_W-1:DATA_W];
        lo_o     <= res_sel[DATA_W-1:0];
        flag_n_o <= flags.n;
        flag_z_o <= flags.z;
        flag_v_o <= flags.v;
        flag_c_o <= flags.c;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o) else $error("valid_o missing"); // R8
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o) else $error("valid_o without strobe"); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(hi_o) && $stable(lo_o) && $stable(flag_c_o))
    else $error("outputs moved while idle"); // R8
  AST_ZERO_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && count_i[CNT_W-1:0] == '0 |=>
      hi_o == $past(hi_i) && !flag_c_o && !flag_v_o)
    else $error("zero count altered operand"); // R2
  AST_SIGN_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> flag_v_o == (hi_o[DATA_W-1] ^ $past(hi_i[DATA_W-1])))
    else $error("V does not track sign change"); // R6
  AST_N_IS_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> flag_n_o == hi_o[DATA_W-1]) else $error("N mismatch"); // R5
  AST_Z_WHOLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> flag_z_o == (hi_o == '0 && lo_o == '0)) else $error("Z mismatch"); // R5
  AST_SINGLE_LO_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !pair_i |=> lo_o == '0) else $error("low word leaked"); // R7
  AST_CNT_HI_SEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && count_i[DATA_W-1:CNT_W] != '0 && count_i[CNT_W-1:0] == '0 |=> !flag_c_o)
    else $error("upper count bits acted"); // R1

endmodule

// File: tb/asr_shift_unit_tb.sv
module asr_shift_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic        pair_i = 1'b0;
  logic [15:0] hi_i = '0, lo_i = '0, count_i = '0;
  logic        valid_o, flag_n_o, flag_z_o, flag_v_o, flag_c_o;
  logic [15:0] hi_o, lo_o;

  always #4 clk = ~clk;

  asr_shift_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .pair_i(pair_i),
    .hi_i(hi_i), .lo_i(lo_i), .count_i(count_i), .valid_o(valid_o),
    .hi_o(hi_o), .lo_o(lo_o), .flag_n_o(flag_n_o), .flag_z_o(flag_z_o),
    .flag_v_o(flag_v_o), .flag_c_o(flag_c_o)
  );

  typedef struct {
    logic [15:0] hi;
    logic [15:0] lo;
    logic        n, z, v, c;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t last_exp;
  bit   have_last = 0;
  bit   mon_on = 0;
  int   checks = 0;
  int   fails = 0;

  function automatic exp_t model(bit pair, logic [15:0] hi, logic [15:0] lo,
                                 logic [15:0] cnt, string tag);
    exp_t e;
    int w = pair ? 32 : 16;
    longint unsigned mask = (64'd1 << w) - 1;
    longint unsigned x = pair ? {32'd0, hi, lo} : {48'd0, hi};
    longint sx;
    longint unsigned res;
    int k = int'(cnt[5:0]);
    bit cy;
    sx = x[w-1] ? longint'(x | ~mask) : longint'(x);
    if (k == 0) begin
      res = x; cy = 0;
    end else if (k < 32) begin
      res = (x << k) & mask;
      cy  = (k <= w) ? x[w-k] : 1'b0;
    end else begin
      res = longint'(sx >>> (64 - k)) & mask;
      cy  = (sx >>> (63 - k)) & 1;
    end
    e.hi  = pair ? res[31:16] : res[15:0];
    e.lo  = pair ? res[15:0] : 16'd0;
    e.n   = res[w-1];
    e.z   = (res == 0);
    e.v   = res[w-1] ^ x[w-1];
    e.c   = cy;
    e.tag = tag;
    return e;
  endfunction

  task automatic send(bit pair, logic [15:0] hi, logic [15:0] lo,
                      logic [15:0] cnt, string tag);
    @(negedge clk);
    valid_i = 1'b1; pair_i = pair; hi_i = hi; lo_i = lo; count_i = cnt;
    exp_q.push_back(model(pair, hi, lo, cnt, tag));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0; pair_i = $urandom_range(0, 1);
      hi_i = $urandom; lo_i = $urandom; count_i = $urandom;
    end
  endtask

  task automatic chk(bit ok, string tag, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic compare(exp_t e);
    chk(hi_o == e.hi, e.tag, "hi_o", hi_o, e.hi);
    chk(lo_o == e.lo, e.tag, "lo_o", lo_o, e.lo);
    chk(flag_c_o == e.c, e.tag, "C", flag_c_o, e.c);
    chk(flag_n_o == e.n && flag_z_o == e.z, "R5", "NZ", {flag_n_o, flag_z_o}, {e.n, e.z});
    chk(flag_v_o == e.v, "R6", "V", flag_v_o, e.v);
  endtask

  // monitor: scoreboard pop on every result, hold check while idle
  always @(negedge clk) begin
    if (mon_on) begin
      if (valid_o) begin
        if (exp_q.size() == 0) begin
          chk(0, "R8", "unexpected valid_o", 1, 0);
        end else begin
          last_exp = exp_q.pop_front();
          have_last = 1;
          compare(last_exp);
        end
      end else if (have_last) begin
        chk(hi_o == last_exp.hi && lo_o == last_exp.lo && flag_c_o == last_exp.c,
            "R8", "idle hold", {hi_o, lo_o}, {last_exp.hi, last_exp.lo});
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(valid_o == 0 && hi_o == 0 && lo_o == 0 &&
        {flag_n_o, flag_z_o, flag_v_o, flag_c_o} == 0, "R9", "reset outputs",
        {valid_o, hi_o, lo_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1;

    // R2 zero count
    send(0, 16'h8001, 16'h1234, 16'h0000, "R2");
    send(1, 16'h4000, 16'h0001, 16'h0000, "R2");
    idle(2);
    // R3 left shifts, single mode boundaries
    send(0, 16'h4001, 16'h0, 16'd1,  "R3");
    send(0, 16'h8001, 16'h0, 16'd1,  "R3");
    send(0, 16'h0003, 16'h0, 16'd15, "R3");
    send(0, 16'h0001, 16'h0, 16'd16, "R3");
    send(0, 16'hFFFF, 16'h0, 16'd17, "R3");
    send(0, 16'hFFFF, 16'h0, 16'd31, "R3");
    // R4 right shifts
    send(0, 16'h8000, 16'h0, 16'd63, "R4");
    send(0, 16'h0003, 16'h0, 16'd63, "R4");
    send(0, 16'h8001, 16'h0, 16'd48, "R4");
    send(0, 16'hC000, 16'h0, 16'd33, "R4");
    send(0, 16'h8000, 16'h0, 16'd32, "R4");
    send(0, 16'h7FFF, 16'h0, 16'd32, "R4");
    idle(3);
    // R1 upper count bits ignored
    send(0, 16'h4001, 16'h0, 16'hFFC1, "R1");
    send(0, 16'h1234, 16'h0, 16'hAB40, "R1");
    send(1, 16'h8000, 16'h0001, 16'h5A7F, "R1");
    // R7 pair mode and single-mode low word
    send(1, 16'h0001, 16'h8000, 16'd1,  "R7");
    send(1, 16'h8000, 16'h0001, 16'd31, "R7");
    send(1, 16'h4000, 16'h0000, 16'd1,  "R7");
    send(1, 16'h8000, 16'h0000, 16'd32, "R7");
    send(1, 16'h0000, 16'h0001, 16'd63, "R7");
    send(1, 16'h0001, 16'h0000, 16'd48, "R7");
    send(0, 16'h0000, 16'hFFFF, 16'd5,  "R7");
    // R5 Z across both words
    send(1, 16'h0000, 16'h0100, 16'd4,  "R5");
    send(1, 16'h0000, 16'h0002, 16'd63, "R5");
    // R6 sign change
    send(0, 16'h7FFF, 16'h0, 16'd1, "R6");
    send(1, 16'h3FFF, 16'hFFFF, 16'd2, "R6");
    idle(2);
    // R8 random mix of strobes and gaps
    for (int i = 0; i < 400; i++) begin
      send($urandom_range(0, 1), $urandom, $urandom, $urandom, "R8");
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    idle(4);
    chk(exp_q.size() == 0, "R8", "results outstanding", exp_q.size(), 0);
    summary();
  end

endmodule